// File: doc/BRIEF.md
# Two-Level Priority Interrupt Controller

This block decides, for an 8-bit microcontroller core, whether an interrupt is taken at an instruction boundary and which one. Six request flags arrive in a fixed polling order: external 0, timer 0, external 1, timer 1, serial, and timer 2. The serial and timer 2 requests are each the OR of two flags, formed outside the block. Each flag is gated by its own enable bit and by a global enable. It is then placed in either the high or the low priority level.

The CPU marks the final cycle of every instruction with `instr_end_i`. On that cycle it also reports whether the instruction was an interrupt return (`reti_i`) or touched the enable or priority registers (`sfr_wr_i`). When an interrupt is taken, the block pulses `take_o` for one cycle and presents a fixed vector at the bottom of program memory. It also pulses a clear strobe back to the edge-type external flag or the timer flag of that source.

Two in-service bits record the priority levels whose handlers are running. A handler can be preempted only by a request of a strictly higher level. Each interrupt return retires the highest level that is in service.

The sequencer has three states:
- `ST_IDLE`: normal polling at each boundary.
- `ST_ACK`: the one cycle in which `take_o` is high.
- `ST_DEFER`: entered after a boundary that ended a return or an enable/priority register access.

Its transitions are:
- IDLE→ACK: an eligible request is present at a plain boundary.
- IDLE→DEFER and DEFER→DEFER: a boundary ends a return or a register access.
- DEFER→ACK: an eligible request is present at a plain boundary.
- DEFER→IDLE: a plain boundary with no eligible request.
- ACK→IDLE: always, on the next cycle.

Top module: `prio_irq_ctrl`

## Requirements
- R1: After reset `take_o`, `clr_o` and `in_service_o` are all zero and `vector_o` is 0000h.
- R2: A request is taken only if its enable bit (`en_i[k]` for request `req_i[k]`) and `ea_i` are both 1; a disabled or globally masked request causes no take.
- R3: A take is decided only on a cycle with `instr_end_i`=1; `take_o` is high for exactly the one cycle after that clock edge.
- R4: Among eligible requests of the same level, the lowest index wins. The index order is 0 external 0, 1 timer 0, 2 external 1, 3 timer 1, 4 serial, 5 timer 2. `vector_o` is 0003h + 8×index: 0003h, 000Bh, 0013h, 001Bh, 0023h or 002Bh.
- R5: A request with `prio_i[k]`=1 (high) wins over every low request, whatever its index.
- R6: A take sets `in_service_o[1]` for a high-level interrupt or `in_service_o[0]` for a low-level one. A high request is eligible only while `in_service_o[1]`=0. A low request is eligible only while `in_service_o` is 00.
- R7: A boundary with `reti_i`=1 clears `in_service_o[1]` if it is set, otherwise `in_service_o[0]`.
- R8: No interrupt is taken at a boundary with `reti_i` or `sfr_wr_i` high. The next boundary without them may take one.
- R9: With a take, `clr_o[k]` pulses for the winning index k when k is 0 to 3. `clr_o[4]` and `clr_o[5]` never pulse. `clr_o` is zero when no take occurs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| instr_end_i | input | 1 | Final cycle of the current instruction |
| reti_i | input | 1 | Instruction ending is an interrupt return |
| sfr_wr_i | input | 1 | Instruction ending accessed the enable or priority registers |
| ea_i | input | 1 | Global interrupt enable |
| en_i | input | 6 | Per-source enable bits |
| prio_i | input | 6 | Per-source level, 1 = high |
| req_i | input | 6 | Request flags in polling order |
| take_o | output | 1 | One-cycle take-interrupt request to the CPU |
| vector_o | output | 16 | Vector address of the last taken interrupt |
| clr_o | output | 6 | One-cycle clear strobe to auto-cleared request flags |
| in_service_o | output | 2 | In-service levels, bit 1 high, bit 0 low |

## Verification
Every result is registered once. `take_o`, `vector_o`, `clr_o` and `in_service_o` therefore change on the clock edge that samples a boundary, and they are valid during the following cycle. The bench drives each boundary on a falling edge and holds it for one cycle. It then samples all outputs at the next falling edge, which is exactly one rising edge later. It also samples before any boundary, so it can confirm that nothing moves between boundaries. Deferral and nesting cases chain several boundaries, and each one is checked in its own post-edge cycle.

// File: rtl/irq_pkg.sv
package irq_pkg;
    localparam int NSRC      = 6;
    localparam int IDXW      = $clog2(NSRC);
    localparam int AW        = 16;
    localparam int VEC_BASE  = 3;
    localparam int VEC_SHIFT = 3;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ACK   = 2'd1,
        ST_DEFER = 2'd2
    } seq_state_t;
endpackage

// File: rtl/irq_pick.sv
module irq_pick #(
    parameter int N = 6,
    parameter int W = $clog2(N)
) (
    input  logic [N-1:0] cand_i,
    output logic         found_o,
    output logic [W-1:0] idx_o
);
    always_comb begin
        found_o = 1'b0;
        idx_o   = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (cand_i[i]) begin
                found_o = 1'b1;
                idx_o   = W'(i);
            end
        end
    end
endmodule

// File: rtl/irq_nest.sv
module irq_nest (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       set_lo_i,
    input  logic       set_hi_i,
    input  logic       retire_i,
    output logic [1:0] isv_o
);
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            isv_o <= 2'b00;
        end else if (retire_i) begin
            if (isv_o[1]) isv_o[1] <= 1'b0;
            else          isv_o[0] <= 1'b0;
        end else begin
            if (set_hi_i) isv_o[1] <= 1'b1;
            if (set_lo_i) isv_o[0] <= 1'b1;
        end
    end
endmodule

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl
    import irq_pkg::*;
#(
    parameter logic [NSRC-1:0] AUTO_CLR = 6'b001111
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            instr_end_i,
    input  logic            reti_i,
    input  logic            sfr_wr_i,
    input  logic            ea_i,
    input  logic [NSRC-1:0] en_i,
    input  logic [NSRC-1:0] prio_i,
    input  logic [NSRC-1:0] req_i,
    output logic            take_o,
    output logic [AW-1:0]   vector_o,
    output logic [NSRC-1:0] clr_o,
    output logic [1:0]      in_service_o
);
    seq_state_t state_q, state_d;

    logic [NSRC-1:0] live;
    logic [NSRC-1:0] cand_hi, cand_lo;
    logic            hi_found, lo_found;
    logic [IDXW-1:0] hi_idx, lo_idx;
    logic            special, plain_end, fire, fire_hi;
    logic [IDXW-1:0] win_idx;

    assign live    = req_i & en_i & {NSRC{ea_i}};
    assign cand_hi = live &  prio_i & {NSRC{~in_service_o[1]}};
    assign cand_lo = live & ~prio_i & {NSRC{in_service_o == 2'b00}};

    irq_pick #(.N(NSRC), .W(IDXW)) u_pick_hi (
        .cand_i (cand_hi),
        .found_o(hi_found),
        .idx_o  (hi_idx)
    );

    irq_pick #(.N(NSRC), .W(IDXW)) u_pick_lo (
        .cand_i (cand_lo),
        .found_o(lo_found),
        .idx_o  (lo_idx)
    );

    assign special   = reti_i | sfr_wr_i;
    assign plain_end = instr_end_i & ~special;
    assign fire      = plain_end & (hi_found | lo_found) & (state_q != ST_ACK);
    assign fire_hi   = hi_found;
    assign win_idx   = hi_found ? hi_idx : lo_idx;

    irq_nest u_nest (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_lo_i(fire & ~fire_hi),
        .set_hi_i(fire &  fire_hi),
        .retire_i(instr_end_i & reti_i),
        .isv_o   (in_service_o)
    );

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (instr_end_i && special) state_d = ST_DEFER;
                else if (fire)              state_d = ST_ACK;
            end
            ST_ACK: begin
                state_d = ST_IDLE;
            end
            ST_DEFER: begin
                if (instr_end_i && special) state_d = ST_DEFER;
                else if (fire)              state_d = ST_ACK;
                else if (instr_end_i)       state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            take_o   <= 1'b0;
            vector_o <= '0;
            clr_o    <= '0;
        end else begin
            take_o <= fire;
            clr_o  <= '0;
            if (fire) begin
                vector_o <= AW'(VEC_BASE) + (AW'(win_idx) << VEC_SHIFT);
                clr_o    <= (NSRC'(1) << win_idx) & AUTO_CLR;
            end
        end
    end
endmodule

// File: rtl/prio_irq_ctrl_chk.sv
module prio_irq_ctrl_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       instr_end_i,
    input logic       reti_i,
    input logic       sfr_wr_i,
    input logic       ea_i,
    input logic       take_o,
    input logic [5:0] clr_o,
    input logic [1:0] in_service_o
);
    AST_TAKE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        take_o |=> !take_o); // R3
    AST_TAKE_AT_BOUNDARY: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(take_o) |-> $past(instr_end_i)); // R3
    AST_TAKE_NEEDS_EA: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(take_o) |-> $past(ea_i)); // R2
    AST_DEFER_SPECIAL: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(take_o) |-> !$past(reti_i) && !$past(sfr_wr_i)); // R8
    AST_HIGH_NOT_PREEMPTED: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(take_o) |-> !$past(in_service_o[1])); // R6
    AST_TAKE_MARKS_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
        take_o |-> in_service_o != 2'b00); // R6
    AST_CLR_WITH_TAKE: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_o != 6'd0) |-> take_o); // R9
    AST_CLR_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(clr_o)); // R9
endmodule

bind prio_irq_ctrl prio_irq_ctrl_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .instr_end_i (instr_end_i),
    .reti_i      (reti_i),
    .sfr_wr_i    (sfr_wr_i),
    .ea_i        (ea_i),
    .take_o      (take_o),
    .clr_o       (clr_o),
    .in_service_o(in_service_o)
);

// File: tb/prio_irq_ctrl_test.sv
module prio_irq_ctrl_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        instr_end_i = 1'b0, reti_i = 1'b0, sfr_wr_i = 1'b0, ea_i = 1'b0;
    logic [5:0]  en_i = '0, prio_i = '0, req_i = '0;
    logic        take_o;
    logic [15:0] vector_o;
    logic [5:0]  clr_o;
    logic [1:0]  in_service_o;
    int          n_chk = 0, n_err = 0;

    always #2 clk = ~clk;

    prio_irq_ctrl uut (.*);

    // {req, en, ea, prio, expected take, expected vector}
    localparam int NV = 10;
    localparam logic [35:0] TV [NV] = '{
        {6'b000001, 6'h3F, 1'b1, 6'b000000, 1'b1, 16'h0003},
        {6'b000110, 6'h3F, 1'b1, 6'b000000, 1'b1, 16'h000B},
        {6'b110000, 6'h3F, 1'b1, 6'b000000, 1'b1, 16'h0023},
        {6'b100001, 6'h3F, 1'b1, 6'b100000, 1'b1, 16'h002B},
        {6'b111111, 6'h3F, 1'b0, 6'b000000, 1'b0, 16'h0000},
        {6'b000011, 6'b000010, 1'b1, 6'b000000, 1'b1, 16'h000B},
        {6'b001000, 6'h3F, 1'b1, 6'b001000, 1'b1, 16'h001B},
        {6'b000000, 6'h3F, 1'b1, 6'b000000, 1'b0, 16'h0000},
        {6'b111111, 6'h00, 1'b1, 6'b000000, 1'b0, 16'h0000},
        {6'b101000, 6'h3F, 1'b1, 6'b101000, 1'b1, 16'h001B}
    };

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic boundary(input logic rt, input logic sw);
        @(negedge clk);
        instr_end_i = 1'b1; reti_i = rt; sfr_wr_i = sw;
        @(negedge clk);
        instr_end_i = 1'b0; reti_i = 1'b0; sfr_wr_i = 1'b0;
    endtask

    task automatic expect_take(input string tag, input logic [15:0] vec, input logic [1:0] isv);
        logic [5:0] idx;
        idx = 6'((vec - 16'h3) >> 3);
        check({tag, " take"}, 32'(take_o), 32'd1);
        check({tag, " vector"}, 32'(vector_o), 32'(vec));
        check({tag, " R9 clr"}, 32'(clr_o), (idx < 4) ? 32'(1 << idx) : 32'd0);
        check({tag, " R6 isv"}, 32'(in_service_o), 32'(isv));
    endtask

    initial begin
        #200000;
        n_err++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R1 take", 32'(take_o), 0);
        check("R1 vector", 32'(vector_o), 0);
        check("R1 clr", 32'(clr_o), 0);
        check("R1 isv", 32'(in_service_o), 0);
        rst_n = 1'b1;

        for (int i = 0; i < NV; i++) begin
            logic [5:0] pr;
            logic [5:0] widx;
            {req_i, en_i, ea_i, prio_i} = TV[i][35:17];
            boundary(1'b0, 1'b0);
            if (TV[i][16]) begin
                widx = 6'((TV[i][15:0] - 16'h3) >> 3);
                pr = prio_i;
                expect_take($sformatf("R2 R4 R5 vec%0d", i), TV[i][15:0],
                            pr[widx] ? 2'b10 : 2'b01);
            end else begin
                check($sformatf("R2 vec%0d no take", i), 32'(take_o), 0);
                check($sformatf("R9 vec%0d no clr", i), 32'(clr_o), 0);
            end
            @(negedge clk);
            check($sformatf("R3 vec%0d single pulse", i), 32'(take_o), 0);
            req_i = '0;
            boundary(1'b1, 1'b0);
            boundary(1'b1, 1'b0);
            check($sformatf("R7 vec%0d cleared", i), 32'(in_service_o), 0);
        end

        // R3: no take without a boundary
        ea_i = 1; en_i = 6'h3F; prio_i = 0; req_i = 6'b000100;
        repeat (4) @(negedge clk);
        check("R3 no boundary", 32'(take_o), 0);

        // R8: deferral after register access, then after return
        boundary(1'b0, 1'b1);
        check("R8 sfr boundary", 32'(take_o), 0);
        boundary(1'b1, 1'b0);
        check("R8 reti boundary", 32'(take_o), 0);
        boundary(1'b0, 1'b0);
        expect_take("R8 next boundary", 16'h0013, 2'b01);

        // R6: low in service blocks other low
        req_i = 6'b000010;
        boundary(1'b0, 1'b0);
        check("R6 low blocked", 32'(take_o), 0);
        // high preempts low
        req_i = 6'b100010; prio_i = 6'b100100;
        boundary(1'b0, 1'b0);
        expect_take("R6 R5 preempt", 16'h002B, 2'b11);
        // high cannot preempt high
        req_i = 6'b000100;
        boundary(1'b0, 1'b0);
        check("R6 high blocked", 32'(take_o), 0);
        // R7: return clears high first
        boundary(1'b1, 1'b0);
        check("R7 high retired", 32'(in_service_o), 32'b01);
        boundary(1'b0, 1'b0);
        expect_take("R6 retake high", 16'h0013, 2'b11);
        req_i = '0;
        boundary(1'b1, 1'b0);
        boundary(1'b1, 1'b0);
        check("R7 all retired", 32'(in_service_o), 0);

        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule